// File: doc/BRIEF.md
# Simultaneous CRT/LCD Vertical Line Mapper

This block lets one frame buffer feed a CRT and a flat panel at the same moment. A single vertical line counter, paced by a per-line tick and locked to CRT timing (480 visible lines in a 525-line frame), produces the CRT line number and vertical sync. From that counter it derives the buffer line to fetch, a panel row-latch strobe with its row number, and a panel frame strobe.

A 2-bit mode select picks how buffer lines reach the two displays: straight through, line doubling (a 240-line image stretched on the CRT), interlace (a 480-line image folded onto a 240-row panel, one field per frame), or even-only (only the even lines go to a 240-row panel). Mode and display enables are taken in only when vertical blanking starts, so no frame mixes two settings. If line doubling is requested while the dual-panel flag is set, the block uses the straight-through mode instead and records a sticky configuration error.

Top module: `vline_mapper`

## Requirements
- R1: After reset the line counter is 0, the interlace field is even (0), the applied setting is mode 00 with both displays disabled, `crt_vsync`, `lcd_latch` and `lcd_frame` are low, `fb_line` and `lcd_row` are 0, and `cfg_err` is low.
- R2: The counter `crt_line` advances by one on each clock edge that sees `line_tick` high, goes from 524 back to 0, and holds its value when `line_tick` is low.
- R3: Mode 00 (straight through): during a visible line n (n < 480), `fb_line` = n, `lcd_latch` is high and `lcd_row` = n. Whenever `lcd_latch` is low, `lcd_row` is 0.
- R4: Mode 01 (line doubling): during a visible line n, `fb_line` = n/2. `lcd_latch` is high only on odd n, with `lcd_row` = n/2, so each row is latched once per pair of lines.
- R5: Mode 10 (interlace): `fb_line` = n. A field bit flips each time the counter wraps to 0. `lcd_latch` is high on visible lines whose bit 0 equals the field bit, with `lcd_row` = n/2.
- R6: Mode 11 (even only): `fb_line` = n. `lcd_latch` is high on every even visible line, with `lcd_row` = n/2.
- R7: If mode 01 is sampled while `dual_panel` is high, mode 00 is applied instead and `cfg_err` goes high. It stays high until reset.
- R8: Mode, dual flag and enables are sampled only on the tick that moves the counter from line 479 to line 480. They take effect from line 480 onward, and changes made at any other time have no effect.
- R9: While the applied CRT enable is low, `crt_vsync` stays inactive. While the applied LCD enable is low, `lcd_latch` and `lcd_frame` stay low. The counter runs in either case. When the CRT is enabled, `crt_vsync` is high (active level) during lines 490 and 491.
- R10: When the LCD is enabled, `lcd_frame` is high during line 0. During blanking lines (480 to 524), `fb_line` is 0 and `lcd_latch` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per CRT line period |
| mode_sel | input | 2 | Requested line-mapping mode (00 normal, 01 double, 10 interlace, 11 even only) |
| dual_panel | input | 1 | Panel is a dual (split) panel |
| crt_en | input | 1 | Requested CRT output enable |
| lcd_en | input | 1 | Requested LCD output enable |
| crt_line | output | 10 | Current CRT line, 0 to 524 |
| crt_vsync | output | 1 | CRT vertical sync |
| fb_line | output | 10 | Frame-buffer line to fetch for this line |
| lcd_latch | output | 1 | Panel row-latch strobe for this line |
| lcd_row | output | 10 | Panel row number that goes with `lcd_latch` |
| lcd_frame | output | 1 | Panel frame strobe |
| cfg_err | output | 1 | Sticky error: line doubling was requested with a dual panel |

## Verification
Every output is decoded combinationally from the counter, field bit and applied-setting registers. Each output therefore changes at the clock edge that takes `line_tick`, with no further delay. A new setting is already in force on line 480 itself. The bench raises `line_tick` for one cycle at a falling edge and compares every output at the following falling edge against its own line, field and setting model. The model applies a setting only when its line count reaches 480, so both mid-frame changes and blanking-start changes are checked at exactly the line where they are due.

// File: rtl/vl_pkg.sv
package vl_pkg;

   typedef enum logic [1:0] {
      VM_NORMAL    = 2'b00,
      VM_DOUBLE    = 2'b01,
      VM_INTERLACE = 2'b10,
      VM_EVEN      = 2'b11
   } vmode_e;

   typedef struct packed {
      vmode_e mode;
      logic   crt_on;
      logic   lcd_on;
   } vcfg_t;

endpackage

// File: rtl/vl_line_ctr.sv
module vl_line_ctr #(
   parameter int TOTAL_LINES = 525,
   parameter int LW          = $clog2(TOTAL_LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_tick,
   output logic [LW-1:0] line_idx,
   output logic          field,
   output logic          frame_end
);

   localparam logic [LW-1:0] LAST_LINE = LW'(TOTAL_LINES - 1);

   logic [LW-1:0] line_q;
   logic          field_q;

   assign frame_end = line_tick && (line_q == LAST_LINE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         field_q <= 1'b0;
      end else if (line_tick) begin
         line_q <= frame_end ? '0 : line_q + 1'b1;
         if (frame_end) field_q <= ~field_q;
      end
   end

   assign line_idx = line_q;
   assign field    = field_q;

   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> line_q == '0);                                        // R2
   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (line_tick && !frame_end) |=> line_q == $past(line_q) + 1'b1);      // R2
   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick |=> $stable(line_q));                                    // R2
   AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> field_q != $past(field_q));                           // R5

endmodule

// File: rtl/vl_cfg_sample.sv
module vl_cfg_sample
   import vl_pkg::*;
#(
   parameter int ACTIVE_LINES = 480,
   parameter int LW           = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_tick,
   input  logic [LW-1:0] line_idx,
   input  logic [1:0]    mode_req,
   input  logic          dual_panel,
   input  logic          crt_en,
   input  logic          lcd_en,
   output vcfg_t         cfg,
   output logic          cfg_err
);

   localparam logic [LW-1:0] LAST_VIS = LW'(ACTIVE_LINES - 1);

   logic  take;
   logic  clash;
   vcfg_t cfg_q;
   logic  err_q;

   assign take  = line_tick && (line_idx == LAST_VIS);
   assign clash = (vmode_e'(mode_req) == VM_DOUBLE) && dual_panel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '{mode: VM_NORMAL, crt_on: 1'b0, lcd_on: 1'b0};
         err_q <= 1'b0;
      end else if (take) begin
         cfg_q.mode   <= clash ? VM_NORMAL : vmode_e'(mode_req);
         cfg_q.crt_on <= crt_en;
         cfg_q.lcd_on <= lcd_en;
         if (clash) err_q <= 1'b1;
      end
   end

   assign cfg     = cfg_q;
   assign cfg_err = err_q;

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(cfg_q));                                          // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);                                                   // R7
   AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (take && clash) |=> (err_q && cfg_q.mode == VM_NORMAL));            // R7

endmodule

// File: rtl/vl_line_map.sv
module vl_line_map
   import vl_pkg::*;
#(
   parameter int ACTIVE_LINES = 480,
   parameter int VSYNC_START  = 490,
   parameter int VSYNC_LINES  = 2,
   parameter bit VSYNC_HIGH   = 1'b1,
   parameter int LW           = 10
) (
   input  logic [LW-1:0] line_idx,
   input  logic          field,
   input  vcfg_t         cfg,
   output logic [LW-1:0] fb_line,
   output logic          lcd_latch,
   output logic [LW-1:0] lcd_row,
   output logic          lcd_frame,
   output logic          crt_vsync
);

   logic          visible;
   logic          pick;
   logic          vs_on;
   logic [LW-1:0] half;

   assign visible = int'(line_idx) < ACTIVE_LINES;
   assign half    = line_idx >> 1;

   always_comb begin
      if (cfg.mode == VM_NORMAL)         pick = 1'b1;
      else if (cfg.mode == VM_DOUBLE)    pick = line_idx[0];
      else if (cfg.mode == VM_INTERLACE) pick = (line_idx[0] == field);
      else                               pick = ~line_idx[0];
   end

   assign fb_line   = !visible ? '0 : ((cfg.mode == VM_DOUBLE) ? half : line_idx);
   assign lcd_latch = cfg.lcd_on && visible && pick;
   assign lcd_row   = !lcd_latch ? '0 : ((cfg.mode == VM_NORMAL) ? line_idx : half);
   assign lcd_frame = cfg.lcd_on && (line_idx == '0);
   assign vs_on     = cfg.crt_on && (int'(line_idx) >= VSYNC_START)
                      && (int'(line_idx) < VSYNC_START + VSYNC_LINES);

   generate
      if (VSYNC_HIGH) begin : g_vs_high
         assign crt_vsync = vs_on;
      end else begin : g_vs_low
         assign crt_vsync = ~vs_on;
      end
   endgenerate

endmodule

// File: rtl/vline_mapper.sv
module vline_mapper
   import vl_pkg::*;
#(
   parameter int ACTIVE_LINES = 480,
   parameter int TOTAL_LINES  = 525,
   parameter int VSYNC_START  = 490,
   parameter int VSYNC_LINES  = 2,
   parameter bit VSYNC_HIGH   = 1'b1,
   localparam int LW          = $clog2(TOTAL_LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_tick,
   input  logic [1:0]    mode_sel,
   input  logic          dual_panel,
   input  logic          crt_en,
   input  logic          lcd_en,
   output logic [LW-1:0] crt_line,
   output logic          crt_vsync,
   output logic [LW-1:0] fb_line,
   output logic          lcd_latch,
   output logic [LW-1:0] lcd_row,
   output logic          lcd_frame,
   output logic          cfg_err
);

   generate
      if (ACTIVE_LINES < 2 || (ACTIVE_LINES % 2) != 0) begin : g_bad_active
         $error("ACTIVE_LINES must be even and at least 2");
      end
      if (ACTIVE_LINES >= TOTAL_LINES) begin : g_bad_total
         $error("TOTAL_LINES must exceed ACTIVE_LINES");
      end
      if (VSYNC_LINES < 1 || VSYNC_START < ACTIVE_LINES
          || VSYNC_START + VSYNC_LINES > TOTAL_LINES) begin : g_bad_vsync
         $error("vertical sync must lie inside the blanking lines");
      end
   endgenerate

   logic          field;
   logic          frame_end;
   vcfg_t         cfg;

   vl_line_ctr #(
      .TOTAL_LINES (TOTAL_LINES),
      .LW          (LW)
   ) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_tick (line_tick),
      .line_idx  (crt_line),
      .field     (field),
      .frame_end (frame_end)
   );

   vl_cfg_sample #(
      .ACTIVE_LINES (ACTIVE_LINES),
      .LW           (LW)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_tick  (line_tick),
      .line_idx   (crt_line),
      .mode_req   (mode_sel),
      .dual_panel (dual_panel),
      .crt_en     (crt_en),
      .lcd_en     (lcd_en),
      .cfg        (cfg),
      .cfg_err    (cfg_err)
   );

   vl_line_map #(
      .ACTIVE_LINES (ACTIVE_LINES),
      .VSYNC_START  (VSYNC_START),
      .VSYNC_LINES  (VSYNC_LINES),
      .VSYNC_HIGH   (VSYNC_HIGH),
      .LW           (LW)
   ) u_map (
      .line_idx  (crt_line),
      .field     (field),
      .cfg       (cfg),
      .fb_line   (fb_line),
      .lcd_latch (lcd_latch),
      .lcd_row   (lcd_row),
      .lcd_frame (lcd_frame),
      .crt_vsync (crt_vsync)
   );

   AST_VSYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.crt_on |-> crt_vsync == !VSYNC_HIGH);                          // R9
   AST_LCD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.lcd_on |-> (!lcd_latch && !lcd_frame));                        // R9
   AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(crt_line) >= ACTIVE_LINES) |-> (!lcd_latch && fb_line == '0)); // R10
   AST_FRAME_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_frame |-> crt_line == '0);                                      // R10
   AST_HALF_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_latch && cfg.mode != VM_NORMAL) |-> int'(lcd_row) < ACTIVE_LINES / 2); // R4

endmodule

// File: tb/vline_mapper_bench.sv
`timescale 1ns/1ps
module vline_mapper_bench;

   localparam int A  = 480;
   localparam int T  = 525;
   localparam int VS = 490;
   localparam int VL = 2;
   localparam int LW = $clog2(T);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_tick = 1'b0;
   logic [1:0]    mode_sel = 2'b00;
   logic          dual_panel = 1'b0;
   logic          crt_en = 1'b0;
   logic          lcd_en = 1'b0;
   logic [LW-1:0] crt_line;
   logic          crt_vsync;
   logic [LW-1:0] fb_line;
   logic          lcd_latch;
   logic [LW-1:0] lcd_row;
   logic          lcd_frame;
   logic          cfg_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model of the line, field and applied setting
   int ln  = 0;
   int fld = 0;
   int em  = 0;
   bit ec  = 1'b0;
   bit el  = 1'b0;
   bit ee  = 1'b0;

   always #10 clk = ~clk;

   vline_mapper u_vline_mapper (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_tick  (line_tick),
      .mode_sel   (mode_sel),
      .dual_panel (dual_panel),
      .crt_en     (crt_en),
      .lcd_en     (lcd_en),
      .crt_line   (crt_line),
      .crt_vsync  (crt_vsync),
      .fb_line    (fb_line),
      .lcd_latch  (lcd_latch),
      .lcd_row    (lcd_row),
      .lcd_frame  (lcd_frame),
      .cfg_err    (cfg_err)
   );

   task automatic check_all(input string tag);
      bit vis;
      bit elat;
      bit efr;
      bit evs;
      int efb;
      int erow;
      vis  = ln < A;
      efb  = vis ? ((em == 1) ? ln / 2 : ln) : 0;
      elat = el && vis && ((em == 0) || (em == 1 && ln % 2 == 1)
                        || (em == 2 && ln % 2 == fld) || (em == 3 && ln % 2 == 0));
      erow = elat ? ((em == 0) ? ln : ln / 2) : 0;
      efr  = el && (ln == 0);
      evs  = ec && (ln >= VS) && (ln < VS + VL);
      n_chk++;
      if (int'(crt_line) != ln || int'(fb_line) != efb || lcd_latch != elat
          || int'(lcd_row) != erow || lcd_frame != efr || crt_vsync != evs
          || cfg_err != ee) begin
         n_bad++;
         $display("FAIL %s: line=%0d fb=%0d latch=%0b row=%0d frame=%0b vs=%0b err=%0b expected line=%0d fb=%0d latch=%0b row=%0d frame=%0b vs=%0b err=%0b",
                  tag, crt_line, fb_line, lcd_latch, lcd_row, lcd_frame, crt_vsync, cfg_err,
                  ln, efb, elat, erow, efr, evs, ee);
      end
   endtask

   task automatic line_step(input string tag);
      @(negedge clk) line_tick = 1'b1;
      @(negedge clk) line_tick = 1'b0;
      ln = (ln == T - 1) ? 0 : ln + 1;
      if (ln == 0) fld = 1 - fld;
      if (ln == A) begin
         if (mode_sel == 2'b01 && dual_panel) begin
            em = 0;
            ee = 1'b1;
         end else begin
            em = int'(mode_sel);
         end
         ec = crt_en;
         el = lcd_en;
      end
      check_all(tag);
   endtask

   task automatic run_lines(input int n, input string tag);
      for (int i = 0; i < n; i++) line_step(tag);
   endtask

   task automatic to_line(input int target, input string tag);
      while (ln != target) line_step(tag);
   endtask

   task automatic setup(input logic [1:0] m, input bit dp, input bit ce, input bit le);
      @(negedge clk);
      mode_sel = m; dual_panel = dp; crt_en = ce; lcd_en = le;
   endtask

   task automatic t_reset();
      check_all("R1 reset state");
   endtask

   task automatic t_hold();
      run_lines(3, "R2 step");
      repeat (6) @(negedge clk);
      check_all("R2 hold without tick");
      to_line(0, "R1 R2 R10 first frame disabled");
   endtask

   task automatic t_normal();
      setup(2'b00, 1'b0, 1'b1, 1'b1);
      to_line(A, "R8 R2 before sample");
      run_lines(T, "R3 R10 normal");
   endtask

   task automatic t_double();
      setup(2'b01, 1'b0, 1'b1, 1'b1);
      to_line(A, "R8 R3 until sample");
      run_lines(T, "R4 R10 line double");
   endtask

   task automatic t_interlace();
      setup(2'b10, 1'b0, 1'b1, 1'b1);
      to_line(A, "R8 R4 until sample");
      run_lines(2 * T, "R5 interlace both fields");
   endtask

   task automatic t_even();
      setup(2'b11, 1'b0, 1'b1, 1'b1);
      to_line(A, "R8 R5 until sample");
      run_lines(T, "R6 even only");
   endtask

   task automatic t_dual();
      setup(2'b01, 1'b1, 1'b1, 1'b1);
      to_line(A, "R7 before clash sample");
      run_lines(T, "R7 fallback to normal");
      setup(2'b11, 1'b0, 1'b1, 1'b1);
      to_line(A, "R7 error sticky");
      run_lines(100, "R7 sticky in even mode");
   endtask

   task automatic t_midframe();
      setup(2'b01, 1'b0, 1'b1, 1'b1);
      run_lines(60, "R8 mid-frame change ignored");
      setup(2'b00, 1'b0, 1'b0, 1'b0);
      to_line(A, "R8 mid-frame change ignored");
      run_lines(T, "R8 R9 applied at blanking");
   endtask

   task automatic t_enables();
      setup(2'b00, 1'b0, 1'b0, 1'b1);
      to_line(A, "R9 before sample");
      run_lines(T, "R9 crt disabled");
      setup(2'b10, 1'b0, 1'b1, 1'b0);
      to_line(A, "R9 before sample");
      run_lines(T, "R9 lcd disabled");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hold();
      t_normal();
      t_double();
      t_interlace();
      t_even();
      t_dual();
      t_midframe();
      t_enables();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule